// File: doc/BRIEF.md
# Integer Arithmetic-Logic Unit with Operation Decode

This block is the combinational integer datapath of a small 32-bit RISC-V style core. Each cycle it takes two operands and the instruction fields that pick an operation. It returns the result within the same cycle and holds no state. Operand B is either the second source register or an immediate that has already been sign-extended. The `imm_i` flag tells the unit which of the two it is being given.

The unit supports these operations: addition and subtraction, signed and unsigned less-than compare, the three bitwise operations, a left shift, and right shifts that are either logical or arithmetic. The 3-bit function field selects the operation family. Instruction bit 30 (`alt_i`) turns addition into subtraction, but only in register-register form. In both forms, bit 30 turns a logical right shift into an arithmetic one. The operand width is a parameter, so the same unit can also be built at a narrow width.

Top module: `int_alu`

## Requirements
- R1: With funct3 = 000, the result is (A + B) mod 2^XLEN whenever `imm_i` = 1 or `alt_i` = 0. An immediate add ignores `alt_i`.
- R2: With funct3 = 000, `alt_i` = 1 and `imm_i` = 0, the result is (A − B) mod 2^XLEN.
- R3: funct3 = 010 compares A and B as signed two's-complement numbers, and funct3 = 011 compares them as unsigned numbers. The result is 1 when A is less than B and 0 otherwise, so all bits above bit 0 are zero.
- R4: funct3 = 100 gives A XOR B, funct3 = 110 gives A OR B, and funct3 = 111 gives A AND B.
- R5: funct3 = 001 shifts A left by the shift amount and fills the vacated bits with zeros.
- R6: funct3 = 101 shifts A right by the shift amount. With `alt_i` = 0 the vacated bits are filled with zeros. With `alt_i` = 1 they are filled with A's top bit. This holds in both the register and the immediate form.
- R7: The shift amount is the low log2(XLEN) bits of B. All higher bits of B have no effect on any shift result.
- R8: For funct3 values other than 000 and 101, neither `alt_i` nor `imm_i` changes the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa_i | input | XLEN | First operand (source register 1) |
| opb_i | input | XLEN | Second operand: source register 2 or sign-extended immediate |
| funct3_i | input | 3 | Operation family field |
| alt_i | input | 1 | Instruction bit 30: subtract / arithmetic-shift select |
| imm_i | input | 1 | 1 when operand B is an immediate |
| res_o | output | XLEN | Operation result |

## Verification
The bench builds two instances. The first uses the default XLEN = 32 and is driven with a grid of boundary operands: zero, one, the most negative and most positive values, all ones, and patterns whose shift fields have high bits set. The second is an XLEN = 8 copy. At this width, every value of operand A, a dense grid of operand B and all 32 combinations of funct3, `alt_i` and `imm_i` can be swept. That sweep reaches every shift amount, every signed/unsigned ordering case and every carry and borrow out of the top bit. Expected results come from an arithmetic model in the bench that works at either width.

// File: rtl/alu_pkg.sv
package alu_pkg;

  typedef enum logic [3:0] {
    ALU_ADD,
    ALU_SUB,
    ALU_SLL,
    ALU_SLT,
    ALU_SLTU,
    ALU_XOR,
    ALU_SRL,
    ALU_SRA,
    ALU_OR,
    ALU_AND
  } alu_op_e;

  localparam logic [2:0] F3_ADD  = 3'b000;
  localparam logic [2:0] F3_SLL  = 3'b001;
  localparam logic [2:0] F3_SLT  = 3'b010;
  localparam logic [2:0] F3_SLTU = 3'b011;
  localparam logic [2:0] F3_XOR  = 3'b100;
  localparam logic [2:0] F3_SR   = 3'b101;
  localparam logic [2:0] F3_OR   = 3'b110;
  localparam logic [2:0] F3_AND  = 3'b111;

endpackage

// File: rtl/alu_decode.sv
module alu_decode
  import alu_pkg::*;
(
  input  logic [2:0] funct3_i,
  input  logic       alt_i,
  input  logic       imm_i,
  output alu_op_e    op_o
);

  always_comb begin
    unique case (funct3_i)
      F3_ADD:  op_o = (alt_i && !imm_i) ? ALU_SUB : ALU_ADD;
      F3_SLL:  op_o = ALU_SLL;
      F3_SLT:  op_o = ALU_SLT;
      F3_SLTU: op_o = ALU_SLTU;
      F3_XOR:  op_o = ALU_XOR;
      F3_SR:   op_o = alt_i ? ALU_SRA : ALU_SRL;
      F3_OR:   op_o = ALU_OR;
      default: op_o = ALU_AND;
    endcase
  end

  // immediate forms never subtract
  always_comb begin
    if (!$isunknown({funct3_i, alt_i, imm_i}) && imm_i)
      p_no_sub_imm_r1: assert (op_o != ALU_SUB);
  end

endmodule

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int unsigned XLEN = 32
) (
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  input  logic            sub_i,
  output logic [XLEN-1:0] sum_o,
  output logic            lt_s_o,
  output logic            lt_u_o
);

  localparam int unsigned MSB = XLEN - 1;

  logic [XLEN:0]   wide;
  logic [XLEN-1:0] b_eff;

  assign b_eff  = b_i ^ {XLEN{sub_i}};
  assign wide   = {1'b0, a_i} + {1'b0, b_eff} + {{XLEN{1'b0}}, sub_i};
  assign sum_o  = wide[MSB:0];
  // no carry out of a - b means a borrow, so a < b unsigned
  assign lt_u_o = ~wide[XLEN];
  assign lt_s_o = (a_i[MSB] ^ b_i[MSB]) ? a_i[MSB] : wide[MSB];

  always_comb begin
    if (!$isunknown({a_i, b_i, sub_i}) && sub_i) begin
      p_borrow_u_r3: assert (lt_u_o == (a_i < b_i));
      p_borrow_s_r3: assert (lt_s_o == ($signed(a_i) < $signed(b_i)));
    end
  end

endmodule

// File: rtl/alu_shift.sv
module alu_shift #(
  parameter int unsigned XLEN = 32,
  localparam int unsigned SHW = $clog2(XLEN)
) (
  input  logic [XLEN-1:0] a_i,
  input  logic [SHW-1:0]  amt_i,
  input  logic            left_i,
  input  logic            arith_i,
  output logic [XLEN-1:0] res_o
);

  logic [XLEN-1:0] a_rev;
  logic [XLEN-1:0] stg [SHW+1];
  logic [XLEN-1:0] out_rev;
  logic            fill;

  // left shifts run through the right shifter on bit-reversed data
  for (genvar i = 0; i < XLEN; i++) begin : g_rev
    assign a_rev[i]   = a_i[XLEN-1-i];
    assign out_rev[i] = stg[SHW][XLEN-1-i];
  end

  assign fill   = arith_i & ~left_i & a_i[XLEN-1];
  assign stg[0] = left_i ? a_rev : a_i;

  for (genvar s = 0; s < SHW; s++) begin : g_stage
    localparam int unsigned STEP = 1 << s;
    assign stg[s+1] = amt_i[s] ? {{STEP{fill}}, stg[s][XLEN-1:STEP]} : stg[s];
  end

  assign res_o = left_i ? out_rev : stg[SHW];

  always_comb begin
    if (!$isunknown({a_i, amt_i, left_i, arith_i})) begin
      if (amt_i == '0)
        p_zero_amt_r7: assert (res_o == a_i);
      if (!left_i && arith_i)
        p_sign_keep_r6: assert (res_o[XLEN-1] == a_i[XLEN-1]);
      if (left_i && amt_i != '0)
        p_lsb_zero_r5: assert (res_o[0] == 1'b0);
    end
  end

endmodule

// File: rtl/int_alu.sv
module int_alu
  import alu_pkg::*;
#(
  parameter int unsigned XLEN = 32,
  localparam int unsigned SHW = $clog2(XLEN)
) (
  input  logic [XLEN-1:0] opa_i,
  input  logic [XLEN-1:0] opb_i,
  input  logic [2:0]      funct3_i,
  input  logic            alt_i,
  input  logic            imm_i,
  output logic [XLEN-1:0] res_o
);

  alu_op_e         op;
  logic            sub_en;
  logic [XLEN-1:0] sum;
  logic            lt_s;
  logic            lt_u;
  logic [XLEN-1:0] sh_res;
  logic            sh_left;
  logic            sh_arith;

  alu_decode u_decode (
    .funct3_i (funct3_i),
    .alt_i    (alt_i),
    .imm_i    (imm_i),
    .op_o     (op)
  );

  // compares share the subtractor
  assign sub_en = (op == ALU_SUB) || (op == ALU_SLT) || (op == ALU_SLTU);

  alu_addsub #(.XLEN(XLEN)) u_addsub (
    .a_i    (opa_i),
    .b_i    (opb_i),
    .sub_i  (sub_en),
    .sum_o  (sum),
    .lt_s_o (lt_s),
    .lt_u_o (lt_u)
  );

  assign sh_left  = (op == ALU_SLL);
  assign sh_arith = (op == ALU_SRA);

  alu_shift #(.XLEN(XLEN)) u_shift (
    .a_i     (opa_i),
    .amt_i   (opb_i[SHW-1:0]),
    .left_i  (sh_left),
    .arith_i (sh_arith),
    .res_o   (sh_res)
  );

  always_comb begin
    unique case (op)
      ALU_ADD, ALU_SUB:          res_o = sum;
      ALU_SLT:                   res_o = {{(XLEN-1){1'b0}}, lt_s};
      ALU_SLTU:                  res_o = {{(XLEN-1){1'b0}}, lt_u};
      ALU_XOR:                   res_o = opa_i ^ opb_i;
      ALU_OR:                    res_o = opa_i | opb_i;
      ALU_AND:                   res_o = opa_i & opb_i;
      ALU_SLL, ALU_SRL, ALU_SRA: res_o = sh_res;
      default:                   res_o = '0;
    endcase
  end

  always_comb begin
    if (!$isunknown({opa_i, opb_i, funct3_i, alt_i, imm_i})) begin
      if (funct3_i == F3_ADD && alt_i && !imm_i)
        p_sub_inverse_r2: assert (res_o + opb_i == opa_i);
      if (funct3_i == F3_ADD && (imm_i || !alt_i))
        p_add_inverse_r1: assert (res_o - opb_i == opa_i);
      if (funct3_i == F3_SLT || funct3_i == F3_SLTU)
        p_cmp_upper_zero_r3: assert (res_o[XLEN-1:1] == '0);
      if (funct3_i == F3_AND)
        p_and_subset_r4: assert ((res_o & ~opa_i) == '0);
      if (funct3_i == F3_OR)
        p_or_superset_r4: assert ((opa_i & ~res_o) == '0);
      if (funct3_i == F3_SR && !alt_i && opb_i[SHW-1:0] != '0)
        p_srl_top_zero_r6: assert (res_o[XLEN-1] == 1'b0);
    end
  end

endmodule

// File: tb/tb_int_alu.sv
`timescale 1ns/1ps
module tb_int_alu;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  int n_chk  = 0;
  int n_fail = 0;
  int cycles = 0;

  logic [31:0] a32, b32;
  logic [2:0]  f3_32;
  logic        alt32, imm32;
  logic [31:0] r32;

  logic [7:0]  a8, b8;
  logic [2:0]  f3_8;
  logic        alt8, imm8;
  logic [7:0]  r8;

  int_alu #(.XLEN(32)) dut (
    .opa_i (a32), .opb_i (b32), .funct3_i (f3_32),
    .alt_i (alt32), .imm_i (imm32), .res_o (r32)
  );

  int_alu #(.XLEN(8)) dut_w8 (
    .opa_i (a8), .opb_i (b8), .funct3_i (f3_8),
    .alt_i (alt8), .imm_i (imm8), .res_o (r8)
  );

  function automatic logic [31:0] model(input logic [31:0] a, input logic [31:0] b,
                                        input logic [2:0] f3, input logic alt,
                                        input logic imm, input int w);
    logic [31:0] m;
    longint      sa, sb, r;
    int          sh;
    m  = (w == 32) ? 32'hFFFF_FFFF : ((32'h1 << w) - 32'h1);
    a  = a & m;
    b  = b & m;
    sh = int'(b) & (w - 1);
    sa = a[w-1] ? longint'(a) - (longint'(1) << w) : longint'(a);
    sb = b[w-1] ? longint'(b) - (longint'(1) << w) : longint'(b);
    case (f3)
      3'd0:    r = (alt && !imm) ? longint'(a) - longint'(b) : longint'(a) + longint'(b);
      3'd1:    r = longint'(a) << sh;
      3'd2:    r = (sa < sb) ? 1 : 0;
      3'd3:    r = (a < b) ? 1 : 0;
      3'd4:    r = longint'(a ^ b);
      3'd5:    r = alt ? (sa >>> sh) : (longint'(a) >> sh);
      3'd6:    r = longint'(a | b);
      default: r = longint'(a & b);
    endcase
    return r[31:0] & m;
  endfunction

  function automatic string tag_of(input logic [2:0] f3, input logic alt, input logic imm);
    if (alt && f3 != 3'd0 && f3 != 3'd5) return "R8";
    case (f3)
      3'd0:         return (alt && !imm) ? "R2" : "R1";
      3'd1:         return "R5";
      3'd2, 3'd3:   return "R3";
      3'd5:         return "R6";
      default:      return "R4";
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      if (n_fail < 20)
        $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic run32(input logic [31:0] a, input logic [31:0] b, input logic [2:0] f3,
                       input logic alt, input logic imm, input string tag);
    a32 = a; b32 = b; f3_32 = f3; alt32 = alt; imm32 = imm;
    #0.5;
    check(tag, r32, model(a, b, f3, alt, imm, 32));
    #0.5;
  endtask

  task automatic finish_run();
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      finish_run();
    end
  end

  logic [31:0] edges [10] = '{32'h0, 32'h1, 32'h8000_0000, 32'h7FFF_FFFF, 32'hFFFF_FFFF,
                              32'h0000_001F, 32'hFFFF_FFE1, 32'h0000_0020, 32'hA5A5_5A5A,
                              32'h8000_0001};

  initial begin
    a32 = '0; b32 = '0; f3_32 = '0; alt32 = 1'b0; imm32 = 1'b0;
    a8 = '0; b8 = '0; f3_8 = '0; alt8 = 1'b0; imm8 = 1'b0;
    #1;
    // idle inputs give zero (R1: 0 + 0)
    check("R1", r32, 32'h0);

    // directed corner values, hand-computed
    run32(32'h7FFF_FFFF, 32'h1, 3'd0, 1'b0, 1'b0, "R1");
    check("R1", r32, 32'h8000_0000);
    run32(32'h5, 32'h3, 3'd0, 1'b1, 1'b1, "R1");
    check("R1", r32, 32'h8);
    run32(32'h0, 32'h1, 3'd0, 1'b1, 1'b0, "R2");
    check("R2", r32, 32'hFFFF_FFFF);
    run32(32'h8000_0000, 32'h7FFF_FFFF, 3'd2, 1'b0, 1'b0, "R3");
    check("R3", r32, 32'h1);
    run32(32'h8000_0000, 32'h7FFF_FFFF, 3'd3, 1'b0, 1'b0, "R3");
    check("R3", r32, 32'h0);
    run32(32'h8000_0000, 32'h1F, 3'd5, 1'b1, 1'b1, "R6");
    check("R6", r32, 32'hFFFF_FFFF);
    run32(32'h8000_0000, 32'h1F, 3'd5, 1'b0, 1'b1, "R6");
    check("R6", r32, 32'h1);
    run32(32'h1, 32'hFFFF_FFE4, 3'd1, 1'b0, 1'b0, "R7");
    check("R7", r32, 32'h10);

    // R7: high bits of B ignored for every shift kind
    for (int k = 0; k < 32; k++) begin
      for (int v = 0; v < 3; v++) begin
        logic [2:0] f = (v == 0) ? 3'd1 : 3'd5;
        a32 = 32'hC3A5_0F81; b32 = 32'hFFFF_FFE0 | k; f3_32 = f; alt32 = (v == 2); imm32 = 1'b1;
        #0.5;
        check("R7", r32, model(32'hC3A5_0F81, k, f, v == 2, 1'b1, 32));
        #0.5;
      end
    end

    // 32-bit boundary grid, all controls
    foreach (edges[i]) begin
      foreach (edges[j]) begin
        for (int c = 0; c < 32; c++) begin
          logic [2:0] f  = c[2:0];
          logic       al = c[3];
          logic       im = c[4];
          run32(edges[i], edges[j], f, al, im, tag_of(f, al, im));
        end
      end
    end

    // 8-bit sweep: all A, dense B, all controls
    for (int ai = 0; ai < 256; ai++) begin
      for (int bi = 0; bi < 38; bi++) begin
        for (int c = 0; c < 32; c++) begin
          logic [7:0] bv = (bi == 37) ? 8'hFF : 8'(bi * 7);
          logic [2:0] f  = c[2:0];
          logic       al = c[3];
          logic       im = c[4];
          a8 = 8'(ai); b8 = bv; f3_8 = f; alt8 = al; imm8 = im;
          #0.25;
          check(tag_of(f, al, im), {24'h0, r8}, model({24'h0, 8'(ai)}, {24'h0, bv}, f, al, im, 8));
          #0.25;
        end
      end
    end

    finish_run();
  end

endmodule